// File: doc/BRIEF.md
# Standby Mode Controller for an 8-bit CPU Core

This block decides when a small 8-bit CPU core stalls to save power and when it runs again. A sleep-instruction strobe from the core moves the block out of its running state into one of three standby states. The choice depends on the control-register bits present at that moment: the peripheral-halt bit and two clock-control bits. In each state the block drives the CPU stall, the peripheral clock gate, the system clock output gate and the memory refresh enable. Separately, the peripheral-halt bit can stop the on-chip peripherals while the CPU keeps running.

Masked external lines, masked internal peripheral sources and the non-maskable interrupt are watched according to the rules of the current standby state. When one of them fires, the block holds the CPU stalled for a fixed restart delay and then releases it. In the first cycle the CPU runs again, the block presents a one-cycle wake-action code. The code tells the core either to service the pending interrupt or to continue straight at the instruction after the sleep instruction, with no acknowledge cycle. The block also decides whether an external bus request may be granted, which matters in the deepest state.

Top module: `lpm_ctrl`

## Requirements
- R1: Right after reset the outputs are cpu_run=1, sysclk_en=1, refresh_en=1 and wake_act=0, and periph_clk_en equals the inverse of io_halt.
- R2: While running, io_halt=1 forces periph_clk_en=0 and leaves cpu_run=1 and sysclk_en=1. io_halt=0 reopens the peripheral clock at once.
- R3: A sleep_exec strobe with io_halt=0 enters SLEEP from the next clock edge on. SLEEP drives cpu_run=0, periph_clk_en=1, sysclk_en=1 and refresh_en=1.
- R4: A sleep_exec strobe with io_halt=1, excluding the R5 combination, enters SYSTEM STOP. That state drives cpu_run=0, periph_clk_en=0, sysclk_en=1 and refresh_en=1.
- R5: A sleep_exec strobe with io_halt=1, ck_sel_hi=0 and ck_sel_lo=1 enters IDLE. That state drives cpu_run=0, periph_clk_en=0, sysclk_en=0 and refresh_en=0.
- R6: In SLEEP, an asserted external or internal source wakes the block only when its enable bit is 1. An asserted source whose enable is 0 leaves the block asleep.
- R7: In SYSTEM STOP and IDLE, internal sources never wake the block, even when enabled. Enabled external lines still wake it.
- R8: nmi wakes the block from any standby state and always yields wake_act=1, whatever the value of irq_glb_en.
- R9: wake_act is 1 (service interrupt) when irq_glb_en=1 or nmi caused the wake, and 2 (resume at next instruction) otherwise. The value is latched at the wake edge. It is nonzero for exactly one cycle, the first cycle in which cpu_run is high again, and 0 at all other times.
- R10: If a wake condition is present at clock edge j, cpu_run stays 0 for the two cycles after edge j and returns to 1 after edge j+2.
- R11: bus_grant_ok equals bus_req in every state except IDLE. In IDLE it is bus_req ANDed with the value bus_rel_en had when the sleep strobe was taken. Changes to bus_rel_en after entry have no effect.
- R12: A sleep_exec strobe that arrives while the block is not running is ignored: the current state and its gate outputs are kept.
- R13: Asserting rst_n low in any state immediately returns the outputs to the R1 values and discards any pending wake action, so no wake_act pulse follows the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_exec | input | 1 | One-cycle strobe: sleep instruction executed |
| io_halt | input | 1 | Control bit that halts on-chip peripherals |
| ck_sel_hi | input | 1 | Clock-control bit, must be 0 to select IDLE |
| ck_sel_lo | input | 1 | Clock-control bit, must be 1 to select IDLE |
| bus_rel_en | input | 1 | Permits bus grant while in IDLE (sampled at entry) |
| irq_glb_en | input | 1 | Global interrupt-enable flag |
| ext_irq_en | input | N_EXT | Per-line enables for external interrupts |
| ext_irq | input | N_EXT | External interrupt request lines |
| int_irq_en | input | N_INT | Per-source enables for internal peripheral interrupts |
| int_irq | input | N_INT | Internal peripheral interrupt requests |
| nmi | input | 1 | Non-maskable interrupt request |
| bus_req | input | 1 | External master bus request |
| cpu_run | output | 1 | 1 lets the CPU advance, 0 stalls it |
| periph_clk_en | output | 1 | Gate for the on-chip peripheral clock |
| sysclk_en | output | 1 | Gate for the system clock output pin |
| refresh_en | output | 1 | Memory refresh enable |
| bus_grant_ok | output | 1 | Permission to grant the bus to an external master |
| wake_act | output | 2 | Wake action: 0 none, 1 service interrupt, 2 resume |

## Verification
The bench sweeps all eight combinations of the three mode-select bits against six source patterns and both values of the global flag. The source patterns are: no request, a disabled external line, an enabled external line, a disabled internal source, an enabled internal source, and nmi. The disabled-source patterns show that enable masking works in every state. The enabled internal source separates SLEEP from the two deeper states. nmi against the flag separates the take-interrupt rule from the resume rule. Directed runs then cover the bus-release value captured at IDLE entry, a sleep strobe while already stalled, and a reset during the restart delay.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_SYSSTOP = 3'd2,
    ST_IDLE    = 3'd3,
    ST_RESTART = 3'd4
  } lpm_state_e;

  typedef enum logic [1:0] {
    WAKE_NONE     = 2'd0,
    WAKE_TAKE_IRQ = 2'd1,
    WAKE_RESUME   = 2'd2
  } wake_act_e;

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lpm_wake_eval.sv
module lpm_wake_eval
  import lpm_pkg::*;
#(
  parameter int N_EXT = 3,
  parameter int N_INT = 4
) (
  input  lpm_state_e       state,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_EXT-1:0] ext_irq_en,
  input  logic [N_INT-1:0] int_irq,
  input  logic [N_INT-1:0] int_irq_en,
  input  logic             nmi,
  input  logic             irq_glb_en,
  output logic             wake_req,
  output logic             take_irq
);

  logic [N_EXT-1:0] ext_hit_v;
  logic [N_INT-1:0] int_hit_v;
  logic             in_standby;
  logic             int_allowed;

  for (genvar e = 0; e < N_EXT; e++) begin : g_ext_mask
    assign ext_hit_v[e] = ext_irq[e] & ext_irq_en[e];
  end

  for (genvar i = 0; i < N_INT; i++) begin : g_int_mask
    assign int_hit_v[i] = int_irq[i] & int_irq_en[i];
  end

  always_comb begin
    in_standby  = (state == ST_SLEEP) || (state == ST_SYSSTOP) || (state == ST_IDLE);
    // peripherals are stopped in the deeper states, so their requests are void
    int_allowed = (state == ST_SLEEP);
    wake_req    = in_standby && (nmi || (|ext_hit_v) || (int_allowed && (|int_hit_v)));
    take_irq    = nmi || irq_glb_en;
  end

endmodule

// File: rtl/lpm_restart_timer.sv
module lpm_restart_timer #(
  parameter int CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);

  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = LOAD;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/lpm_gate_decode.sv
module lpm_gate_decode
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       io_halt,
  input  logic       bus_rel_lat,
  input  logic       bus_req,
  output logic       cpu_run,
  output logic       periph_clk_en,
  output logic       sysclk_en,
  output logic       refresh_en,
  output logic       bus_grant_ok
);

  always_comb begin
    cpu_run       = 1'b1;
    periph_clk_en = !io_halt;
    sysclk_en     = 1'b1;
    refresh_en    = 1'b1;
    bus_grant_ok  = bus_req;
    unique case (state)
      ST_RUN: ;
      ST_SLEEP,
      ST_RESTART: cpu_run = 1'b0;
      ST_SYSSTOP: begin
        cpu_run       = 1'b0;
        periph_clk_en = 1'b0;
      end
      ST_IDLE: begin
        cpu_run       = 1'b0;
        periph_clk_en = 1'b0;
        sysclk_en     = 1'b0;
        refresh_en    = 1'b0;
        bus_grant_ok  = bus_req && bus_rel_lat;
      end
      default: cpu_run = 1'b0;
    endcase
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int N_EXT       = 3,
  parameter int N_INT       = 4,
  parameter int RESTART_CYC = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_exec,
  input  logic             io_halt,
  input  logic             ck_sel_hi,
  input  logic             ck_sel_lo,
  input  logic             bus_rel_en,
  input  logic             irq_glb_en,
  input  logic [N_EXT-1:0] ext_irq_en,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_INT-1:0] int_irq_en,
  input  logic [N_INT-1:0] int_irq,
  input  logic             nmi,
  input  logic             bus_req,
  output logic             cpu_run,
  output logic             periph_clk_en,
  output logic             sysclk_en,
  output logic             refresh_en,
  output logic             bus_grant_ok,
  output logic [1:0]       wake_act
);

  logic       rst_sync_n;
  lpm_state_e state_q, state_d;
  logic       act_irq_q, act_irq_d;
  logic       bus_rel_q, bus_rel_d;
  wake_act_e  wake_q, wake_d;
  logic       wake_req, take_irq, tmr_start, tmr_done, sleep_take;

  lpm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpm_wake_eval #(.N_EXT(N_EXT), .N_INT(N_INT)) u_wake_eval (
    .state      (state_q),
    .ext_irq    (ext_irq),
    .ext_irq_en (ext_irq_en),
    .int_irq    (int_irq),
    .int_irq_en (int_irq_en),
    .nmi        (nmi),
    .irq_glb_en (irq_glb_en),
    .wake_req   (wake_req),
    .take_irq   (take_irq)
  );

  lpm_restart_timer #(.CYCLES(RESTART_CYC)) u_restart (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (tmr_start),
    .done  (tmr_done)
  );

  lpm_gate_decode u_gates (
    .state         (state_q),
    .io_halt       (io_halt),
    .bus_rel_lat   (bus_rel_q),
    .bus_req       (bus_req),
    .cpu_run       (cpu_run),
    .periph_clk_en (periph_clk_en),
    .sysclk_en     (sysclk_en),
    .refresh_en    (refresh_en),
    .bus_grant_ok  (bus_grant_ok)
  );

  assign sleep_take = (state_q == ST_RUN) && sleep_exec;
  assign tmr_start  = wake_req;

  // next-state process
  always_comb begin
    state_d   = state_q;
    act_irq_d = act_irq_q;
    bus_rel_d = bus_rel_q;
    wake_d    = WAKE_NONE;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_take) begin
          if (!io_halt)                     state_d = ST_SLEEP;
          else if (!ck_sel_hi && ck_sel_lo) state_d = ST_IDLE;
          else                              state_d = ST_SYSSTOP;
        end
      end
      ST_SLEEP, ST_SYSSTOP, ST_IDLE: begin
        if (wake_req) state_d = ST_RESTART;
      end
      ST_RESTART: begin
        if (tmr_done) begin
          state_d = ST_RUN;
          wake_d  = act_irq_q ? WAKE_TAKE_IRQ : WAKE_RESUME;
        end
      end
      default: state_d = ST_RUN;
    endcase
    if (sleep_take) bus_rel_d = bus_rel_en;
    if (tmr_start)  act_irq_d = take_irq;
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_RUN;
      act_irq_q <= 1'b0;
      bus_rel_q <= 1'b0;
      wake_q    <= WAKE_NONE;
    end else begin
      state_q   <= state_d;
      act_irq_q <= act_irq_d;
      bus_rel_q <= bus_rel_d;
      wake_q    <= wake_d;
    end
  end

  assign wake_act = wake_q;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_exec,
  input logic       bus_req,
  input logic       cpu_run,
  input logic       periph_clk_en,
  input logic       sysclk_en,
  input logic       refresh_en,
  input logic       bus_grant_ok,
  input logic [1:0] wake_act
);

  AST_DEEP_GATES_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !sysclk_en |-> (!refresh_en && !periph_clk_en && !cpu_run)); // R5

  AST_STALL_ONLY_ON_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_run) |-> $past(sleep_exec)); // R3

  AST_WAKE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_act != 2'd0) |=> (wake_act == 2'd0)); // R9

  AST_WAKE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_act != 2'd0) |-> (cpu_run && !$past(cpu_run))); // R10

  AST_RELEASE_HAS_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_run) |-> (wake_act == 2'd1 || wake_act == 2'd2)); // R9

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant_ok |-> bus_req); // R11

  AST_NO_CODE_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_act != 2'd3); // R9

endmodule

bind lpm_ctrl lpm_ctrl_chk u_lpm_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sleep_exec    (sleep_exec),
  .bus_req       (bus_req),
  .cpu_run       (cpu_run),
  .periph_clk_en (periph_clk_en),
  .sysclk_en     (sysclk_en),
  .refresh_en    (refresh_en),
  .bus_grant_ok  (bus_grant_ok),
  .wake_act      (wake_act)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;

  localparam int NE = 3;
  localparam int NI = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep_exec, io_halt, ck_sel_hi, ck_sel_lo, bus_rel_en, irq_glb_en;
  logic [NE-1:0] ext_irq_en, ext_irq;
  logic [NI-1:0] int_irq_en, int_irq;
  logic          nmi, bus_req;
  logic          cpu_run, periph_clk_en, sysclk_en, refresh_en, bus_grant_ok;
  logic [1:0]    wake_act;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lpm_ctrl #(.N_EXT(NE), .N_INT(NI)) u_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .io_halt(io_halt),
    .ck_sel_hi(ck_sel_hi), .ck_sel_lo(ck_sel_lo), .bus_rel_en(bus_rel_en),
    .irq_glb_en(irq_glb_en), .ext_irq_en(ext_irq_en), .ext_irq(ext_irq),
    .int_irq_en(int_irq_en), .int_irq(int_irq), .nmi(nmi), .bus_req(bus_req),
    .cpu_run(cpu_run), .periph_clk_en(periph_clk_en), .sysclk_en(sysclk_en),
    .refresh_en(refresh_en), .bus_grant_ok(bus_grant_ok), .wake_act(wake_act)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    sleep_exec = 0; io_halt = 0; ck_sel_hi = 0; ck_sel_lo = 0; bus_rel_en = 0;
    irq_glb_en = 0; ext_irq_en = '0; ext_irq = '0; int_irq_en = '0; int_irq = '0;
    nmi = 0; bus_req = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_exec = 1;
    @(negedge clk);
    sleep_exec = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // sweep: mode bits x source pattern x global flag
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int src = 0; src < 6; src++) begin
        for (int g = 0; g < 2; g++) begin
          int  mode;
          bit  wake;
          int  exp_act;
          string tg;
          idle_inputs();
          io_halt    = cfg[2];
          ck_sel_hi  = cfg[1];
          ck_sel_lo  = cfg[0];
          irq_glb_en = g[0];
          ext_irq_en = 3'b001;
          int_irq_en = 4'b0001;
          do_reset();
          check(cpu_run, 1, "R1 run after reset");
          check(sysclk_en, 1, "R1 sysclk after reset");
          check(refresh_en, 1, "R1 refresh after reset");
          check(wake_act, 0, "R1 wake_act after reset");
          check(periph_clk_en, !io_halt, "R2 periph gate while running");
          // mode: 1 SLEEP, 2 SYSTEM STOP, 3 IDLE
          mode = !io_halt ? 1 : ((!ck_sel_hi && ck_sel_lo) ? 3 : 2);
          tg = (mode == 1) ? "R3" : ((mode == 2) ? "R4" : "R5");
          pulse_sleep();
          check(cpu_run, 0, {tg, " run stalled"});
          check(periph_clk_en, mode == 1, {tg, " periph gate"});
          check(sysclk_en, mode != 3, {tg, " sysclk gate"});
          check(refresh_en, mode != 3, {tg, " refresh"});
          // source patterns
          wake = 0;
          case (src)
            1: begin ext_irq = 3'b010; end
            2: begin ext_irq = 3'b100; ext_irq_en = 3'b101; wake = 1; end
            3: begin int_irq = 4'b0100; end
            4: begin int_irq = 4'b1000; int_irq_en = 4'b1001; wake = (mode == 1); end
            5: begin nmi = 1; wake = 1; end
            default: ;
          endcase
          exp_act = (src == 5 || g == 1) ? 1 : 2;
          if (src == 5)                tg = "R8";
          else if (src == 4 && mode != 1) tg = "R7";
          else if (src == 2 && mode != 1) tg = "R7";
          else                          tg = "R6";
          @(negedge clk);
          ext_irq = '0; int_irq = '0; nmi = 0;
          check(cpu_run, 0, "R10 stalled cycle 1");
          @(negedge clk);
          check(cpu_run, 0, "R10 stalled cycle 2");
          @(negedge clk);
          check(cpu_run, wake, {tg, " R10 run after delay"});
          check(wake_act, wake ? exp_act : 0, {tg, " R9 wake action"});
          @(negedge clk);
          check(wake_act, 0, "R9 action cleared");
          if (!wake) check(sysclk_en, mode != 3, {tg, " state kept"});
        end
      end
    end

    // R2: peripheral halt while running
    idle_inputs();
    do_reset();
    io_halt = 1;
    #1;
    check(periph_clk_en, 0, "R2 halt closes periph");
    check(cpu_run, 1, "R2 cpu keeps running");
    check(sysclk_en, 1, "R2 sysclk kept");
    io_halt = 0;
    #1;
    check(periph_clk_en, 1, "R2 periph reopens");

    // R11: bus release captured at IDLE entry
    idle_inputs();
    do_reset();
    io_halt = 1; ck_sel_lo = 1; bus_rel_en = 1; bus_req = 1;
    #1;
    check(bus_grant_ok, 1, "R11 grant while running");
    pulse_sleep();
    bus_rel_en = 0;
    @(negedge clk);
    check(sysclk_en, 0, "R11 in idle");
    check(bus_grant_ok, 1, "R11 grant with captured release");
    bus_req = 0;
    #1;
    check(bus_grant_ok, 0, "R11 no request no grant");
    idle_inputs();
    do_reset();
    io_halt = 1; ck_sel_lo = 1; bus_req = 1;
    pulse_sleep();
    bus_rel_en = 1;
    @(negedge clk);
    check(bus_grant_ok, 0, "R11 idle without captured release");
    idle_inputs();
    do_reset();
    bus_req = 1;
    pulse_sleep();
    check(bus_grant_ok, 1, "R11 sleep grants");

    // R12: strobe while stalled is ignored
    idle_inputs();
    do_reset();
    pulse_sleep();
    io_halt = 1; ck_sel_lo = 1;
    pulse_sleep();
    @(negedge clk);
    check(cpu_run, 0, "R12 still stalled");
    check(sysclk_en, 1, "R12 sleep not changed to idle");
    check(refresh_en, 1, "R12 refresh kept");

    // R13: reset during restart discards action
    idle_inputs();
    do_reset();
    irq_glb_en = 1;
    pulse_sleep();
    nmi = 1;
    @(negedge clk);
    nmi = 0;
    rst_n = 0;
    #1;
    check(cpu_run, 1, "R13 run on reset");
    check(sysclk_en, 1, "R13 sysclk on reset");
    check(wake_act, 0, "R13 action on reset");
    @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(wake_act, 0, "R13 no action after reset");
      check(cpu_run, 1, "R13 running after reset");
    end

    finish_run();
  end

endmodule